// File: doc/BRIEF.md
# Integer Add/Subtract Execution Unit with Flags

This block is the add/subtract slice of a 32-bit integer execution pipe. Each cycle it may accept one operation: two register operand values, a 16-bit immediate, the current carry bit and sticky summary-overflow bit, a 4-bit operation code, and two modifier bits. One asks for signed overflow to be recorded and the other asks for the condition field to be recorded. One clock later it presents the 32-bit result, the new carry, overflow and summary-overflow bits, and a 4-bit condition field. Each of these comes with a write-enable, so that the surrounding pipeline knows which architectural state to update.

Every operation reduces to one 33-bit addition, `X + Y + cin`. X is the first register operand or its complement. Y is the second operand, all ones, zero, or an immediate that is either sign-extended or shifted into the high half. The carry-in is zero, one or the incoming carry bit. Subtraction follows the "subtract from" convention, so the result is the second operand minus the first. The decoder also sets which flags an operation may write.

Top module: `int_addsub_unit`

## Requirements
- R1: Outputs are registered. When `in_valid` is high, `out_valid` and all results appear exactly one clock later. When `out_valid` is low, `ca_wr`, `ov_wr` and `cr0_wr` are low.
- R2: Add family (codes 0 ADD, 1 ADDC, 2 ADDE, 3 ADDME, 4 ADDZE) yields A+B, A+B, A+B+CA, A+0xFFFFFFFF+CA and A+CA respectively, modulo 2^32.
- R3: Subtract-from family (codes 5 SUBF, 6 SUBFC, 7 SUBFE, 8 SUBFME, 9 SUBFZE) yields ~A+B+1, ~A+B+1, ~A+B+CA, ~A+0xFFFFFFFF+CA and ~A+CA respectively.
- R4: Code 10 NEG yields ~A+1. Negating 0x80000000 returns 0x80000000, and this case counts as a signed overflow.
- R5: Immediate forms: 11 ADDI gives A+sext(imm); 12 ADDIS gives A+(imm<<16); 13 ADDIC gives A+sext(imm); 14 SUBFIC gives ~A+sext(imm)+1; 15 SUBFIS gives ~A+(imm<<16)+1. For codes 11 and 12 only, `ra_is_zero` high replaces A with 0.
- R6: Codes 1–4, 6–9, 13 and 14 raise `ca_wr` and deliver the carry out of bit 31 on `ca_out`. All other codes leave `ca_wr` low and pass `ca_in` to `ca_out`.
- R7: For register codes 0–10 with `oe` high, `ov_wr` is high and `ov_out` flags signed overflow of the 32-bit sum. Immediate codes 11–15 never record overflow, whatever `oe` is. When `ov_wr` is low, `ov_out` is 0.
- R8: `so_out` equals `so_in` OR the recorded overflow, so it is never cleared by this unit.
- R9: With `rc` high, codes 0–10, 13 and 14 raise `cr0_wr`, and `cr0` is {LT,GT,EQ,SO} in bits 3..0. These come from a signed compare of the result with zero, with SO taken from `so_out`. Codes 11, 12 and 15 never record it. When `cr0_wr` is low, `cr0` is 0.
- R10: While `rst_n` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present this cycle |
| op | input | 4 | Operation code (see R2–R5) |
| oe | input | 1 | Record-overflow modifier |
| rc | input | 1 | Record-condition-field modifier |
| ra_is_zero | input | 1 | First source specifier is register 0 |
| ra_val | input | 32 | First operand A |
| rb_val | input | 32 | Second operand B |
| imm | input | 16 | Immediate field |
| ca_in | input | 1 | Current carry bit |
| so_in | input | 1 | Current summary-overflow bit |
| out_valid | output | 1 | Result valid |
| result | output | 32 | Sum |
| ca_out | output | 1 | New carry bit |
| ca_wr | output | 1 | Carry bit write enable |
| ov_out | output | 1 | Recorded overflow |
| ov_wr | output | 1 | Overflow write enable |
| so_out | output | 1 | New summary-overflow bit |
| cr0 | output | 4 | Condition field {LT,GT,EQ,SO} |
| cr0_wr | output | 1 | Condition field write enable |

## Verification
The hardest condition to reach is a signed overflow that coincides with a consumed carry. One example is ADDE or SUBFME, where the carry-in alone pushes the sum across the sign boundary. Another is NEG on the most negative value. The stimulus sweeps both carry values across operand corners: zero, one, two, both signed extremes, all ones, and a negative sign-extended value. It also rotates the modifier bits and the incoming summary-overflow bit, so that every code meets these boundaries with each recording combination.

// File: rtl/addsub_pkg.sv
package addsub_pkg;

    typedef enum logic [3:0] {
        OP_ADD    = 4'd0,
        OP_ADDC   = 4'd1,
        OP_ADDE   = 4'd2,
        OP_ADDME  = 4'd3,
        OP_ADDZE  = 4'd4,
        OP_SUBF   = 4'd5,
        OP_SUBFC  = 4'd6,
        OP_SUBFE  = 4'd7,
        OP_SUBFME = 4'd8,
        OP_SUBFZE = 4'd9,
        OP_NEG    = 4'd10,
        OP_ADDI   = 4'd11,
        OP_ADDIS  = 4'd12,
        OP_ADDIC  = 4'd13,
        OP_SUBFIC = 4'd14,
        OP_SUBFIS = 4'd15
    } op_e;

    typedef enum logic [2:0] {
        YSEL_REG  = 3'd0,
        YSEL_ONES = 3'd1,
        YSEL_ZERO = 3'd2,
        YSEL_SEXT = 3'd3,
        YSEL_HIGH = 3'd4
    } ysel_e;

    typedef enum logic [1:0] {
        CIN_ZERO = 2'd0,
        CIN_ONE  = 2'd1,
        CIN_CA   = 2'd2
    } cinsel_e;

    typedef struct packed {
        logic    invert_x;
        logic    zero_x_ok;
        ysel_e   ysel;
        cinsel_e cinsel;
        logic    writes_ca;
        logic    ov_allowed;
        logic    cr_allowed;
    } ctrl_t;

endpackage

// File: rtl/addsub_decode.sv
module addsub_decode
    import addsub_pkg::*;
(
    input  logic [3:0] op,
    output ctrl_t      ctrl
);
    always_comb begin
        ctrl            = '0;
        ctrl.ysel       = YSEL_REG;
        ctrl.cinsel     = CIN_ZERO;
        ctrl.ov_allowed = 1'b1;
        ctrl.cr_allowed = 1'b1;
        unique case (op_e'(op))
            OP_ADD:    ;
            OP_ADDC:   ctrl.writes_ca = 1'b1;
            OP_ADDE:   begin ctrl.writes_ca = 1'b1; ctrl.cinsel = CIN_CA; end
            OP_ADDME:  begin ctrl.writes_ca = 1'b1; ctrl.cinsel = CIN_CA; ctrl.ysel = YSEL_ONES; end
            OP_ADDZE:  begin ctrl.writes_ca = 1'b1; ctrl.cinsel = CIN_CA; ctrl.ysel = YSEL_ZERO; end
            OP_SUBF:   begin ctrl.invert_x = 1'b1; ctrl.cinsel = CIN_ONE; end
            OP_SUBFC:  begin ctrl.invert_x = 1'b1; ctrl.cinsel = CIN_ONE; ctrl.writes_ca = 1'b1; end
            OP_SUBFE:  begin ctrl.invert_x = 1'b1; ctrl.cinsel = CIN_CA; ctrl.writes_ca = 1'b1; end
            OP_SUBFME: begin
                ctrl.invert_x = 1'b1; ctrl.cinsel = CIN_CA;
                ctrl.writes_ca = 1'b1; ctrl.ysel = YSEL_ONES;
            end
            OP_SUBFZE: begin
                ctrl.invert_x = 1'b1; ctrl.cinsel = CIN_CA;
                ctrl.writes_ca = 1'b1; ctrl.ysel = YSEL_ZERO;
            end
            OP_NEG:    begin ctrl.invert_x = 1'b1; ctrl.cinsel = CIN_ONE; ctrl.ysel = YSEL_ZERO; end
            OP_ADDI:   begin
                ctrl.ysel = YSEL_SEXT; ctrl.zero_x_ok = 1'b1;
                ctrl.ov_allowed = 1'b0; ctrl.cr_allowed = 1'b0;
            end
            OP_ADDIS:  begin
                ctrl.ysel = YSEL_HIGH; ctrl.zero_x_ok = 1'b1;
                ctrl.ov_allowed = 1'b0; ctrl.cr_allowed = 1'b0;
            end
            OP_ADDIC:  begin ctrl.ysel = YSEL_SEXT; ctrl.writes_ca = 1'b1; ctrl.ov_allowed = 1'b0; end
            OP_SUBFIC: begin
                ctrl.ysel = YSEL_SEXT; ctrl.writes_ca = 1'b1; ctrl.ov_allowed = 1'b0;
                ctrl.invert_x = 1'b1; ctrl.cinsel = CIN_ONE;
            end
            OP_SUBFIS: begin
                ctrl.ysel = YSEL_HIGH; ctrl.invert_x = 1'b1; ctrl.cinsel = CIN_ONE;
                ctrl.ov_allowed = 1'b0; ctrl.cr_allowed = 1'b0;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/addsub_operands.sv
module addsub_operands
    import addsub_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int IMM_W = 16
) (
    input  ctrl_t             ctrl,
    input  logic              ra_is_zero,
    input  logic [XLEN-1:0]   ra_val,
    input  logic [XLEN-1:0]   rb_val,
    input  logic [IMM_W-1:0]  imm,
    input  logic              ca_in,
    output logic [XLEN-1:0]   x_opnd,
    output logic [XLEN-1:0]   y_opnd,
    output logic              cin
);
    localparam int PAD_W = XLEN - IMM_W;

    logic [XLEN-1:0] a_eff;
    logic [XLEN-1:0] imm_sext;
    logic [XLEN-1:0] imm_high;

    assign imm_sext = {{PAD_W{imm[IMM_W-1]}}, imm};
    assign imm_high = {imm, {PAD_W{1'b0}}};

    always_comb begin
        a_eff  = (ctrl.zero_x_ok && ra_is_zero) ? '0 : ra_val;
        x_opnd = ctrl.invert_x ? ~a_eff : a_eff;
        unique case (ctrl.ysel)
            YSEL_ONES: y_opnd = '1;
            YSEL_ZERO: y_opnd = '0;
            YSEL_SEXT: y_opnd = imm_sext;
            YSEL_HIGH: y_opnd = imm_high;
            default:   y_opnd = rb_val;
        endcase
        unique case (ctrl.cinsel)
            CIN_ONE: cin = 1'b1;
            CIN_CA:  cin = ca_in;
            default: cin = 1'b0;
        endcase
    end
endmodule

// File: rtl/addsub_adder.sv
module addsub_adder #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] x_opnd,
    input  logic [XLEN-1:0] y_opnd,
    input  logic            cin,
    output logic [XLEN-1:0] sum,
    output logic            cout,
    output logic            ovf
);
    localparam int MSB = XLEN - 1;

    logic [XLEN:0] wide;

    assign wide = {1'b0, x_opnd} + {1'b0, y_opnd} + {{XLEN{1'b0}}, cin};
    assign sum  = wide[MSB:0];
    assign cout = wide[XLEN];
    assign ovf  = (x_opnd[MSB] == y_opnd[MSB]) && (sum[MSB] != x_opnd[MSB]);
endmodule

// File: rtl/int_addsub_unit.sv
module int_addsub_unit
    import addsub_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int IMM_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [3:0]        op,
    input  logic              oe,
    input  logic              rc,
    input  logic              ra_is_zero,
    input  logic [XLEN-1:0]   ra_val,
    input  logic [XLEN-1:0]   rb_val,
    input  logic [IMM_W-1:0]  imm,
    input  logic              ca_in,
    input  logic              so_in,
    output logic              out_valid,
    output logic [XLEN-1:0]   result,
    output logic              ca_out,
    output logic              ca_wr,
    output logic              ov_out,
    output logic              ov_wr,
    output logic              so_out,
    output logic [3:0]        cr0,
    output logic              cr0_wr
);
    localparam int MSB = XLEN - 1;

    typedef struct packed {
        logic            valid;
        logic [XLEN-1:0] res;
        logic            ca;
        logic            ca_we;
        logic            ov;
        logic            ov_we;
        logic            so;
        logic [3:0]      cr;
        logic            cr_we;
    } stage_t;

    ctrl_t           ctrl;
    logic [XLEN-1:0] x_opnd, y_opnd, sum;
    logic            cin, cout, ovf;
    stage_t          st_d, st_q;

    addsub_decode u_dec (.op(op), .ctrl(ctrl));

    addsub_operands #(.XLEN(XLEN), .IMM_W(IMM_W)) u_opnd (
        .ctrl(ctrl), .ra_is_zero(ra_is_zero), .ra_val(ra_val), .rb_val(rb_val),
        .imm(imm), .ca_in(ca_in), .x_opnd(x_opnd), .y_opnd(y_opnd), .cin(cin)
    );

    addsub_adder #(.XLEN(XLEN)) u_add (
        .x_opnd(x_opnd), .y_opnd(y_opnd), .cin(cin),
        .sum(sum), .cout(cout), .ovf(ovf)
    );

    always_comb begin
        logic rec_ov, new_so;
        rec_ov      = in_valid && oe && ctrl.ov_allowed;
        new_so      = so_in | (rec_ov & ovf);
        st_d        = '0;
        st_d.valid  = in_valid;
        if (in_valid) begin
            st_d.res   = sum;
            st_d.ca_we = ctrl.writes_ca;
            st_d.ca    = ctrl.writes_ca ? cout : ca_in;
            st_d.ov_we = rec_ov;
            st_d.ov    = rec_ov & ovf;
            st_d.so    = new_so;
            st_d.cr_we = rc && ctrl.cr_allowed;
            if (st_d.cr_we) begin
                st_d.cr = {sum[MSB], !sum[MSB] && (sum != '0), sum == '0, new_so};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.valid;
    assign result    = st_q.res;
    assign ca_out    = st_q.ca;
    assign ca_wr     = st_q.ca_we;
    assign ov_out    = st_q.ov;
    assign ov_wr     = st_q.ov_we;
    assign so_out    = st_q.so;
    assign cr0       = st_q.cr;
    assign cr0_wr    = st_q.cr_we;
endmodule

// File: rtl/addsub_checker.sv
module addsub_checker #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic [3:0]      op,
    input logic            so_in,
    input logic            out_valid,
    input logic [XLEN-1:0] result,
    input logic            ov_wr,
    input logic            ov_out,
    input logic            so_out,
    input logic [3:0]      cr0,
    input logic            cr0_wr,
    input logic            ca_wr
);
    a_r1_latency: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!ca_wr && !ov_wr && !cr0_wr));

    a_r7_imm_no_ov: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && ov_wr) |-> ($past(op) < 4'd11));

    a_r7_ov_gated: assert property (@(posedge clk) disable iff (!rst_n)
        ov_out |-> ov_wr);

    a_r8_sticky_so: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(in_valid && so_in)) |-> so_out);

    a_r9_cr_one_hot: assert property (@(posedge clk) disable iff (!rst_n)
        cr0_wr |-> $onehot(cr0[3:1]));

    a_r9_cr_eq: assert property (@(posedge clk) disable iff (!rst_n)
        (cr0_wr && result == '0) |-> (cr0[1] && cr0[0] == so_out));
endmodule

bind int_addsub_unit addsub_checker #(.XLEN(XLEN)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .so_in(so_in),
    .out_valid(out_valid), .result(result), .ov_wr(ov_wr), .ov_out(ov_out),
    .so_out(so_out), .cr0(cr0), .cr0_wr(cr0_wr), .ca_wr(ca_wr)
);

// File: tb/int_addsub_unit_bench.sv
`timescale 1ns/1ps
module int_addsub_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  op = '0;
    logic        oe = 1'b0, rc = 1'b0, ra_is_zero = 1'b0;
    logic [31:0] ra_val = '0, rb_val = '0;
    logic [15:0] imm = '0;
    logic        ca_in = 1'b0, so_in = 1'b0;
    logic        out_valid, ca_out, ca_wr, ov_out, ov_wr, so_out, cr0_wr;
    logic [31:0] result;
    logic [3:0]  cr0;

    int vectors = 0;
    int misses  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    int_addsub_unit u_int_addsub_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .oe(oe), .rc(rc),
        .ra_is_zero(ra_is_zero), .ra_val(ra_val), .rb_val(rb_val), .imm(imm),
        .ca_in(ca_in), .so_in(so_in), .out_valid(out_valid), .result(result),
        .ca_out(ca_out), .ca_wr(ca_wr), .ov_out(ov_out), .ov_wr(ov_wr),
        .so_out(so_out), .cr0(cr0), .cr0_wr(cr0_wr)
    );

    function automatic logic [31:0] corner(input int k);
        case (k)
            0: return 32'h0000_0000;
            1: return 32'h0000_0001;
            2: return 32'h0000_0002;
            3: return 32'h7FFF_FFFF;
            4: return 32'h8000_0000;
            5: return 32'hFFFF_FFFF;
            6: return 32'h1234_5678;
            default: return 32'hFFFF_8000;
        endcase
    endfunction

    function automatic logic [15:0] imm_corner(input int k);
        case (k)
            0: return 16'h0000;
            1: return 16'h0001;
            2: return 16'h7FFF;
            3: return 16'h8000;
            4: return 16'hFFFF;
            5: return 16'h1234;
            6: return 16'h00FF;
            default: return 16'hFF00;
        endcase
    endfunction

    task automatic cmp(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        if (act !== exp) begin
            misses++;
            $display("FAIL %s %s op=%0d a=%h b=%h imm=%h: actual %h expected %h",
                     req, what, op, ra_val, rb_val, imm, act, exp);
        end
    endtask

    task automatic check_vector();
        logic [31:0] a, x, y, sext, high;
        logic cin, cawr, ovok, crok, cout, ov, rec, so_e, cr_we_e;
        logic [32:0] s33;
        longint sg;
        logic [3:0] cr_e;
        string rq;
        sext = {{16{imm[15]}}, imm};
        high = {imm, 16'h0000};
        a = ((op == 4'd11 || op == 4'd12) && ra_is_zero) ? 32'h0 : ra_val;
        cawr = 1'b0; ovok = (op < 4'd11); crok = 1'b1;
        x = a; y = rb_val; cin = 1'b0;
        case (op)
            4'd0: rq = "R2";
            4'd1: begin rq = "R2"; cawr = 1'b1; end
            4'd2: begin rq = "R2"; cawr = 1'b1; cin = ca_in; end
            4'd3: begin rq = "R2"; cawr = 1'b1; cin = ca_in; y = 32'hFFFF_FFFF; end
            4'd4: begin rq = "R2"; cawr = 1'b1; cin = ca_in; y = 32'h0; end
            4'd5: begin rq = "R3"; x = ~a; cin = 1'b1; end
            4'd6: begin rq = "R3"; x = ~a; cin = 1'b1; cawr = 1'b1; end
            4'd7: begin rq = "R3"; x = ~a; cin = ca_in; cawr = 1'b1; end
            4'd8: begin rq = "R3"; x = ~a; cin = ca_in; cawr = 1'b1; y = 32'hFFFF_FFFF; end
            4'd9: begin rq = "R3"; x = ~a; cin = ca_in; cawr = 1'b1; y = 32'h0; end
            4'd10: begin rq = "R4"; x = ~a; cin = 1'b1; y = 32'h0; end
            4'd11: begin rq = "R5"; y = sext; crok = 1'b0; end
            4'd12: begin rq = "R5"; y = high; crok = 1'b0; end
            4'd13: begin rq = "R5"; y = sext; cawr = 1'b1; end
            4'd14: begin rq = "R5"; x = ~a; y = sext; cin = 1'b1; cawr = 1'b1; end
            default: begin rq = "R5"; x = ~a; y = high; cin = 1'b1; crok = 1'b0; end
        endcase
        s33  = {1'b0, x} + {1'b0, y} + {32'h0, cin};
        cout = s33[32];
        sg   = longint'($signed(x)) + longint'($signed(y)) + longint'(cin);
        ov   = (sg > 64'sd2147483647) || (sg < -64'sd2147483648);
        rec  = oe && ovok;
        so_e = so_in | (rec & ov);
        cr_we_e = rc && crok;
        cr_e = cr_we_e ? {$signed(s33[31:0]) < 0, $signed(s33[31:0]) > 0,
                          s33[31:0] == 32'h0, so_e} : 4'h0;
        vectors++;
        cmp("R1", "out_valid", {31'h0, out_valid}, 32'h1);
        cmp(rq,   "result",    result, s33[31:0]);
        cmp("R6", "ca_wr",     {31'h0, ca_wr}, {31'h0, cawr});
        cmp("R6", "ca_out",    {31'h0, ca_out}, {31'h0, cawr ? cout : ca_in});
        cmp("R7", "ov_wr",     {31'h0, ov_wr}, {31'h0, rec});
        cmp("R7", "ov_out",    {31'h0, ov_out}, {31'h0, rec & ov});
        cmp("R8", "so_out",    {31'h0, so_out}, {31'h0, so_e});
        cmp("R9", "cr0_wr",    {31'h0, cr0_wr}, {31'h0, cr_we_e});
        cmp("R9", "cr0",       {28'h0, cr0}, {28'h0, cr_e});
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            misses++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        vectors++;   // R10 reset state
        cmp("R10", "outputs in reset",
            {result[27:0], out_valid, ca_out | ca_wr | ov_out | ov_wr, so_out | cr0_wr, |cr0},
            32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        vectors++;   // R1 idle after reset
        cmp("R1", "idle enables", {29'h0, ca_wr, ov_wr, cr0_wr}, 32'h0);

        // directed R4: negate of most negative value with overflow recording
        in_valid = 1'b1; op = 4'd10; oe = 1'b1; rc = 1'b1; ra_val = 32'h8000_0000;
        so_in = 1'b0; ca_in = 1'b0;
        @(negedge clk);
        check_vector();
        cmp("R4", "neg min result", result, 32'h8000_0000);
        cmp("R4", "neg min ov", {31'h0, ov_out}, 32'h1);

        for (int i = 0; i < 8; i++) begin
            for (int j = 0; j < 8; j++) begin
                for (int k = 0; k < 16; k++) begin
                    for (int c = 0; c < 4; c++) begin
                        in_valid   = 1'b1;
                        op         = 4'(k);
                        ra_val     = corner(i);
                        rb_val     = corner(j);
                        imm        = imm_corner((i + j) % 8);
                        ca_in      = c[0];
                        so_in      = c[1];
                        oe         = ((i + j + c) % 4) >= 2;
                        rc         = ((i + k + c) % 2) == 0;
                        ra_is_zero = ((i + j + k) % 3) == 0;
                        @(negedge clk);
                        check_vector();
                    end
                end
            end
        end

        in_valid = 1'b0;
        @(negedge clk);
        vectors++;   // R1 bubble clears valid and enables
        cmp("R1", "bubble", {28'h0, out_valid, ca_wr, ov_wr, cr0_wr}, 32'h0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule